// File: doc/BRIEF.md
# Segment Access Rights and Bounds Checker

This block judges one memory access against an already loaded segment descriptor. It is meant for a processor running in protected mode outside 64-bit mode. The caller presents the following with a one-cycle request strobe:

- the segment slot and whether its selector is null;
- the descriptor's readable, writable and expand-down attributes, its base and its limit;
- the code segment's default operand-size bit and the per-access address-size override;
- the kind of access (read, write or fetch), a store-check flag that makes a read be judged as a write, the access size code and the linear address.

One cycle later the block raises a done pulse and a general-protection fault flag.

The access is checked in three ways:
- The null-selector check spares a small set of system and internal slots.
- The read and write rights checks apply only to the data-class slots.
- The bounds check works out the segment offset in 16 or 32 bits, as the size bits select. It tests both the first and the last byte of the access, and the comparison is inverted for expand-down segments.

When protection is off (real mode), or when the core is in 64-bit mode, the block never reports a fault.

Top module: `seg_access_guard`

## Requirements
- R1: After reset, `chk_done` and `gp_fault` are both 0.
- R2: A request accepted on a clock edge with `req_valid` high gives `chk_done` = 1 for exactly the next cycle. With no request, `chk_done` is 0 and `gp_fault` keeps its last value.
- R3: When `prot_en` is 0, or `long_mode` is 1, the result is `gp_fault` = 0 whatever the other inputs are.
- R4: A null selector (`sel_null` = 1) faults for slots 0 to 5. Slots 6 (internal), 7 (internal), 8 (descriptor table) and 9 (interrupt table) are exempt from the null check.
- R5: For the data-class slots 0 to 6, a write (`acc_kind` = 1) faults when `attr_wr` = 0. So does any access with `store_chk` = 1. Slots 7 to 9 skip the rights checks.
- R6: For data-class slots, a read (`acc_kind` = 0) faults when `attr_rd` = 0. A fetch (`acc_kind` = 2) is not subject to the read right.
- R7: The address width is 16 bits when `cs_dflt32` and `asize_ovr` are equal. It is 32 bits when they differ.
- R8: The offset is `lin_addr - seg_base`, truncated to the address width. The end offset is `offset + bytes - 1`, computed one bit wider so that a carry out is kept. Here bytes = 1, 2, 4 or 8 for `acc_size` codes 0, 1, 2 and 3.
- R9: For an expand-up segment (`attr_xdn` = 0), the access faults when the offset or the end offset is greater than `seg_limit`.
- R10: For an expand-down segment (`attr_xdn` = 1), the access faults when the offset or the end offset is less than or equal to `seg_limit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| prot_en | input | 1 | Protected mode enabled |
| long_mode | input | 1 | Core is in 64-bit mode |
| seg_idx | input | 4 | Segment slot number |
| sel_null | input | 1 | Selector of the slot is null |
| attr_rd | input | 1 | Segment readable |
| attr_wr | input | 1 | Segment writable |
| attr_xdn | input | 1 | Segment expands down |
| seg_base | input | 32 | Segment base |
| seg_limit | input | 32 | Segment limit |
| cs_dflt32 | input | 1 | Code segment default-size bit |
| asize_ovr | input | 1 | Address-size override for this access |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| store_chk | input | 1 | Judge the access as a write |
| acc_size | input | 2 | Size code: bytes = 1 << code |
| lin_addr | input | 32 | Linear address of the first byte |
| chk_done | output | 1 | Result valid pulse |
| gp_fault | output | 1 | General-protection fault result |

## Verification
Both results are due one clock edge after the edge that samples `req_valid`. Nothing else in the block has latency.

The bench drives each request on a falling edge and reads `chk_done` and `gp_fault` on the next falling edge, half a cycle after the capturing edge. It drops the strobe at that same point. One falling edge later it confirms that `chk_done` has cleared and that `gp_fault` has held its value.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam int SLOT_W         = 4;
  localparam int DATA_SLOT_LAST = 6;  // slots 0..6 carry read/write rights
  localparam int NULL_FREE_LO   = 6;  // slots 6..9 exempt from null check
  localparam int NULL_FREE_HI   = 9;
  localparam int SHORT_AW       = 16;
  localparam int SIZE_CODE_W    = 2;

  function automatic logic slot_is_data(input logic [SLOT_W-1:0] slot);
    return int'(slot) <= DATA_SLOT_LAST;
  endfunction

  function automatic logic slot_null_exempt(input logic [SLOT_W-1:0] slot);
    return (int'(slot) >= NULL_FREE_LO) && (int'(slot) <= NULL_FREE_HI);
  endfunction

  // Equal size bits select the short address width.
  function automatic logic use_short_width(input logic dflt32, input logic ovr);
    return dflt32 == ovr;
  endfunction

endpackage

// File: rtl/seg_rights_check.sv
module seg_rights_check
  import seg_guard_pkg::*;
(
  input  logic [SLOT_W-1:0] slot,
  input  logic              sel_null,
  input  logic              can_read,
  input  logic              can_write,
  input  acc_kind_e         kind,
  input  logic              store_chk,
  output logic              null_hit,
  output logic              write_hit,
  output logic              read_hit
);

  logic data_slot;
  logic wants_write;

  always_comb begin
    data_slot   = slot_is_data(slot);
    wants_write = (kind == ACC_WRITE) || store_chk;
    null_hit    = sel_null && !slot_null_exempt(slot);
    write_hit   = data_slot && wants_write && !can_write;
    read_hit    = data_slot && (kind == ACC_READ) && !can_read;
  end

endmodule

// File: rtl/seg_bound_check.sv
module seg_bound_check
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]      base,
  input  logic [ADDR_W-1:0]      limit,
  input  logic [ADDR_W-1:0]      lin,
  input  logic                   dflt32,
  input  logic                   ovr,
  input  logic [SIZE_CODE_W-1:0] size_code,
  input  logic                   expand_down,
  output logic                   short_mode,
  output logic [ADDR_W-1:0]      first_off,
  output logic [ADDR_W:0]        last_off,
  output logic                   bound_hit
);

  localparam int EXT_W = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] SHORT_MASK = ADDR_W'((64'd1 << SHORT_AW) - 64'd1);

  function automatic logic [ADDR_W-1:0] calc_offset(
    input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b, input logic is_short);
    logic [ADDR_W-1:0] d;
    d = a - b;
    return is_short ? (d & SHORT_MASK) : d;
  endfunction

  function automatic logic [EXT_W-1:0] calc_last(
    input logic [ADDR_W-1:0] off, input logic [SIZE_CODE_W-1:0] code);
    logic [EXT_W-1:0] nbytes;
    nbytes = EXT_W'(1) << code;
    return {1'b0, off} + nbytes - EXT_W'(1);
  endfunction

  logic [EXT_W-1:0] lim_ext;
  logic             up_out;
  logic             down_in;

  always_comb begin
    short_mode = use_short_width(dflt32, ovr);
    first_off  = calc_offset(lin, base, short_mode);
    last_off   = calc_last(first_off, size_code);
    lim_ext    = {1'b0, limit};
    up_out     = ({1'b0, first_off} > lim_ext) || (last_off > lim_ext);
    down_in    = ({1'b0, first_off} <= lim_ext) || (last_off <= lim_ext);
    bound_hit  = expand_down ? down_in : up_out;
  end

  // R8: the widened end offset never wraps below the first offset
  always_comb begin
    assert_end_no_wrap_R8: assert (last_off >= {1'b0, first_off});
  end

endmodule

// File: rtl/seg_access_guard.sv
module seg_access_guard
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   prot_en,
  input  logic                   long_mode,
  input  logic [SLOT_W-1:0]      seg_idx,
  input  logic                   sel_null,
  input  logic                   attr_rd,
  input  logic                   attr_wr,
  input  logic                   attr_xdn,
  input  logic [ADDR_W-1:0]      seg_base,
  input  logic [ADDR_W-1:0]      seg_limit,
  input  logic                   cs_dflt32,
  input  logic                   asize_ovr,
  input  logic [1:0]             acc_kind,
  input  logic                   store_chk,
  input  logic [SIZE_CODE_W-1:0] acc_size,
  input  logic [ADDR_W-1:0]      lin_addr,
  output logic                   chk_done,
  output logic                   gp_fault
);

  logic              null_hit, write_hit, read_hit, bound_hit;
  logic              short_mode;
  logic [ADDR_W-1:0] first_off;
  logic [ADDR_W:0]   last_off;
  logic              check_on;
  logic              rights_hit;
  logic              fault_next;

  seg_rights_check u_rights (
    .slot      (seg_idx),
    .sel_null  (sel_null),
    .can_read  (attr_rd),
    .can_write (attr_wr),
    .kind      (acc_kind_e'(acc_kind)),
    .store_chk (store_chk),
    .null_hit  (null_hit),
    .write_hit (write_hit),
    .read_hit  (read_hit)
  );

  seg_bound_check #(.ADDR_W(ADDR_W)) u_bound (
    .base        (seg_base),
    .limit       (seg_limit),
    .lin         (lin_addr),
    .dflt32      (cs_dflt32),
    .ovr         (asize_ovr),
    .size_code   (acc_size),
    .expand_down (attr_xdn),
    .short_mode  (short_mode),
    .first_off   (first_off),
    .last_off    (last_off),
    .bound_hit   (bound_hit)
  );

  always_comb begin
    check_on   = prot_en && !long_mode;
    rights_hit = null_hit || write_hit || read_hit;
    fault_next = check_on && (rights_hit || bound_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_done <= 1'b0;
      gp_fault <= 1'b0;
    end else begin
      chk_done <= req_valid;
      if (req_valid) gp_fault <= fault_next;
    end
  end

  assert_done_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> chk_done);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!chk_done && $stable(gp_fault)));
  assert_bypass_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !check_on) |=> !gp_fault);
  assert_null_faults_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && check_on && null_hit) |=> gp_fault);
  assert_write_faults_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && check_on && write_hit) |=> gp_fault);
  assert_read_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && check_on && read_hit) |=> gp_fault);
  assert_up_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && check_on && !attr_xdn && bound_hit) |=> gp_fault);
  assert_down_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && check_on && attr_xdn && bound_hit) |=> gp_fault);
  assert_clean_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rights_hit && !bound_hit) |=> !gp_fault);
  // R7: short width forces the upper offset bits to zero
  assert_short_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    short_mode |-> (first_off[ADDR_W-1:SHORT_AW] == '0));

endmodule

// File: tb/test_seg_access_guard.sv
module test_seg_access_guard;

  typedef struct packed {
    logic        prot;
    logic        lng;
    logic [3:0]  idx;
    logic        nul;
    logic        rd;
    logic        wr;
    logic        xdn;
    logic        dflt;
    logic        ovr;
    logic [1:0]  kind;
    logic        sc;
    logic [1:0]  sz;
    logic [31:0] base;
    logic [31:0] limit;
    logic [31:0] addr;
    logic        exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    // R9 expand-up: last byte at limit, one past, first past
    '{1,0,4'd3,0,1,1,0,1,0,2'd0,0,2'd2,32'h1000,32'h0FFF,32'h1FFC,0,8'd9},
    '{1,0,4'd3,0,1,1,0,1,0,2'd0,0,2'd2,32'h1000,32'h0FFF,32'h1FFD,1,8'd9},
    '{1,0,4'd3,0,1,1,0,1,0,2'd0,0,2'd2,32'h1000,32'h0FFF,32'h2000,1,8'd9},
    // R7 width selection, 1-byte at 0x10002, limit 0xFFFF
    '{1,0,4'd3,0,1,1,0,0,0,2'd0,0,2'd0,32'h0,32'hFFFF,32'h10002,0,8'd7},
    '{1,0,4'd3,0,1,1,0,1,1,2'd0,0,2'd0,32'h0,32'hFFFF,32'h10002,0,8'd7},
    '{1,0,4'd3,0,1,1,0,1,0,2'd0,0,2'd0,32'h0,32'hFFFF,32'h10002,1,8'd7},
    '{1,0,4'd3,0,1,1,0,0,1,2'd0,0,2'd0,32'h0,32'hFFFF,32'h10002,1,8'd7},
    // R8 16-bit end offset carries past 0xFFFF
    '{1,0,4'd3,0,1,1,0,0,0,2'd0,0,2'd2,32'h0,32'hFFFF,32'h1FFFE,1,8'd8},
    '{1,0,4'd3,0,1,1,0,0,0,2'd0,0,2'd1,32'h0,32'hFFFF,32'h1FFFE,0,8'd8},
    // R8 32-bit end carry and base subtraction wrap
    '{1,0,4'd3,0,1,1,0,1,0,2'd0,0,2'd2,32'h0,32'hFFFFFFFF,32'hFFFFFFFE,1,8'd8},
    '{1,0,4'd3,0,1,1,0,1,0,2'd0,0,2'd0,32'h0,32'hFFFFFFFF,32'hFFFFFFFF,0,8'd8},
    '{1,0,4'd3,0,1,1,0,1,0,2'd0,0,2'd0,32'h10,32'hFFFFFFF0,32'h8,1,8'd8},
    '{1,0,4'd3,0,1,1,0,1,0,2'd3,0,2'd3,32'h0,32'h0FFF,32'h0FF8,0,8'd8},
    '{1,0,4'd3,0,1,1,0,1,0,2'd0,0,2'd3,32'h0,32'h0FFF,32'h0FF9,1,8'd8},
    // R10 expand-down
    '{1,0,4'd3,0,1,1,1,1,0,2'd0,0,2'd2,32'h0,32'h0FFF,32'h1000,0,8'd10},
    '{1,0,4'd3,0,1,1,1,1,0,2'd0,0,2'd2,32'h0,32'h0FFF,32'h0FFE,1,8'd10},
    '{1,0,4'd3,0,1,1,1,1,0,2'd0,0,2'd0,32'h0,32'h0FFF,32'h0FFF,1,8'd10},
    '{1,0,4'd3,0,1,1,1,1,0,2'd0,0,2'd3,32'h0,32'h0FFF,32'h1000,0,8'd10},
    // R4 null selector
    '{1,0,4'd3,1,1,1,0,1,0,2'd0,0,2'd0,32'h0,32'hFFFF,32'h10,1,8'd4},
    '{1,0,4'd0,1,1,1,0,1,0,2'd0,0,2'd0,32'h0,32'hFFFF,32'h10,1,8'd4},
    '{1,0,4'd9,1,1,1,0,1,0,2'd0,0,2'd0,32'h0,32'hFFFF,32'h10,0,8'd4},
    '{1,0,4'd6,1,1,1,0,1,0,2'd0,0,2'd0,32'h0,32'hFFFF,32'h10,0,8'd4},
    // R5 write rights and store-check
    '{1,0,4'd3,0,1,0,0,1,0,2'd1,0,2'd0,32'h0,32'hFFFF,32'h10,1,8'd5},
    '{1,0,4'd3,0,1,0,0,1,0,2'd0,1,2'd0,32'h0,32'hFFFF,32'h10,1,8'd5},
    '{1,0,4'd3,0,1,0,0,1,0,2'd0,0,2'd0,32'h0,32'hFFFF,32'h10,0,8'd5},
    '{1,0,4'd8,0,0,0,0,1,0,2'd1,0,2'd0,32'h0,32'hFFFF,32'h10,0,8'd5},
    '{1,0,4'd6,0,1,0,0,1,0,2'd1,0,2'd0,32'h0,32'hFFFF,32'h10,1,8'd5},
    // R6 read right, fetch exempt
    '{1,0,4'd3,0,0,1,0,1,0,2'd0,0,2'd0,32'h0,32'hFFFF,32'h10,1,8'd6},
    '{1,0,4'd3,0,0,1,0,1,0,2'd2,0,2'd0,32'h0,32'hFFFF,32'h10,0,8'd6},
    // R3 bypass: real mode and 64-bit mode with every fault source set
    '{0,0,4'd3,1,0,0,0,1,0,2'd1,0,2'd2,32'h0,32'h0,32'h100,0,8'd3},
    '{1,1,4'd3,1,0,0,0,1,0,2'd1,0,2'd2,32'h0,32'h0,32'h100,0,8'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        prot_en = 1'b0, long_mode = 1'b0;
  logic [3:0]  seg_idx = '0;
  logic        sel_null = 1'b0, attr_rd = 1'b0, attr_wr = 1'b0, attr_xdn = 1'b0;
  logic [31:0] seg_base = '0, seg_limit = '0, lin_addr = '0;
  logic        cs_dflt32 = 1'b0, asize_ovr = 1'b0, store_chk = 1'b0;
  logic [1:0]  acc_kind = '0, acc_size = '0;
  logic        chk_done, gp_fault;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  seg_access_guard i_seg_access_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .prot_en(prot_en), .long_mode(long_mode), .seg_idx(seg_idx),
    .sel_null(sel_null), .attr_rd(attr_rd), .attr_wr(attr_wr),
    .attr_xdn(attr_xdn), .seg_base(seg_base), .seg_limit(seg_limit),
    .cs_dflt32(cs_dflt32), .asize_ovr(asize_ovr), .acc_kind(acc_kind),
    .store_chk(store_chk), .acc_size(acc_size), .lin_addr(lin_addr),
    .chk_done(chk_done), .gp_fault(gp_fault)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    prot_en = v.prot; long_mode = v.lng; seg_idx = v.idx; sel_null = v.nul;
    attr_rd = v.rd; attr_wr = v.wr; attr_xdn = v.xdn; cs_dflt32 = v.dflt;
    asize_ovr = v.ovr; acc_kind = v.kind; store_chk = v.sc; acc_size = v.sz;
    seg_base = v.base; seg_limit = v.limit; lin_addr = v.addr;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    check("R1 done", chk_done, 1'b0);
    check("R1 fault", gp_fault, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle done", chk_done, 1'b0);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      apply(v);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check($sformatf("R2 done vec %0d", i), chk_done, 1'b1);
      check($sformatf("R%0d fault vec %0d", v.req, i), gp_fault, v.exp);
    end

    // R2: idle cycles hold the result while inputs change
    apply(VECS[1]);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 setup fault", gp_fault, 1'b1);
    apply(VECS[0]);
    @(negedge clk);
    check("R2 done drops", chk_done, 1'b0);
    check("R2 fault held", gp_fault, 1'b1);
    @(negedge clk);
    check("R2 fault still held", gp_fault, 1'b1);

    // R2: back-to-back requests each give a result
    apply(VECS[0]);
    req_valid = 1'b1;
    @(negedge clk);
    check("R2 b2b first done", chk_done, 1'b1);
    check("R9 b2b first fault", gp_fault, 1'b0);
    apply(VECS[2]);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 b2b second done", chk_done, 1'b1);
    check("R9 b2b second fault", gp_fault, 1'b1);

    // R1: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset fault", gp_fault, 1'b0);
    check("R1 reset done", chk_done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule